// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter With Borrow/Carry

This block is a reversible binary counter, four bits wide by default. It has two separate count lines. A rising edge on the up line adds one to the count and a rising edge on the down line takes one away. When one line is toggling, the other is held high. Both lines are asynchronous to the block. Each passes through a synchronizer on a single fast system clock, and the rising edges are detected in that clock domain.

The block has two override inputs, a master clear (active high) and a parallel load (active low). Both are level inputs sampled on the system clock. The clear forces the count to zero. The load copies a data word into the count. Both take priority over counting.

Two active-low terminal outputs are provided, carry and borrow. Carry follows the low phase of the up line while the count is at its maximum. Borrow follows the low phase of the down line while the count is zero. A chain of such counters can therefore ripple carries and borrows from one stage into the count lines of the next.

Top module: `dcc_counter`

## Requirements
- R1: A cycle with `clr_i` high sets `count_o` to 0 at the next system-clock edge, whatever `load_n_i`, `data_i`, `up_i` and `dn_i` are doing.
- R2: A cycle with `clr_i` low and `load_n_i` low sets `count_o` to `data_i` at the next edge, whatever the count lines are doing. A count edge that arrives while load is low is dropped.
- R3: When `up_i` rises and is first sampled high at system-clock edge k, `count_o` becomes count+1 at edge k+2.
- R4: When `dn_i` rises and is first sampled high at edge k, `count_o` becomes count−1 at edge k+2.
- R5: Counting up from the all-ones value gives 0. Counting down from 0 gives the all-ones value (15 at the default width).
- R6: While `up_i` and `dn_i` both stay high and neither override is active, `count_o` does not change.
- R7: If rising edges on both count lines are detected in the same system-clock cycle, `count_o` does not change.
- R8: `carry_n_o` is 0 exactly when `count_o` is all ones and the synchronized level of `up_i` is 0. Otherwise it is 1. The synchronized level follows `up_i` two edges later, and there is no extra register after it.
- R9: `borrow_n_o` is 0 exactly when `count_o` is 0 and the synchronized level of `dn_i` is 0. Otherwise it is 1. The timing is the same as in R8.
- R10: A count line that is still low when clear or load is released is counted on its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples every input |
| clr_i | input | 1 | Master clear, active high, highest priority |
| load_n_i | input | 1 | Parallel load, active low |
| data_i | input | CNT_W | Value copied into the count on load |
| up_i | input | 1 | Up-count line; counts on its rising edge |
| dn_i | input | 1 | Down-count line; counts on its rising edge |
| count_o | output | CNT_W | Current count |
| carry_n_o | output | 1 | Carry, active low, repeats the low phase of up at the maximum count |
| borrow_n_o | output | 1 | Borrow, active low, repeats the low phase of down at zero |

## Verification
The bench targets the following corner cases:
- Wrap-around in both directions. A design that saturated, or used a width one bit too wide, would read 15 or 16 where 0 is expected.
- The exact cycle at which carry releases and the count steps after the up line rises. A design with a registered terminal output or a missing synchronizer stage would be off by one cycle at one of these samples.
- Overrides that arrive while a count line is low, followed by a later rising edge that must still count. A design that reinitialized its edge history to low, or kept no history, would lose that edge or count a spurious one.
- Simultaneous rising edges on both lines. A design with an implicit priority would step the count where it should hold.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  // Index of each count line in the synchronizer vector
  localparam int LINE_UP = 0;
  localparam int LINE_DN = 1;
  localparam int N_LINES = 2;

  // Action applied to the count register in a cycle
  typedef enum logic [2:0] {
    MODE_HOLD  = 3'd0,
    MODE_UP    = 3'd1,
    MODE_DOWN  = 3'd2,
    MODE_LOAD  = 3'd3,
    MODE_CLEAR = 3'd4
  } dcc_mode_e;
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o
);
  localparam int LAST = STAGES - 1;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Idle level of a count line is high, so clear primes the chain high
    always_ff @(posedge clk_i) begin
      if (clr_i) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[l]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl_o[l]  = chain_q[LAST];
    assign rise_o[l] = chain_q[LAST] & ~prev_q;

    // A detected edge is a single-cycle event
    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (clr_i)
      rise_o[l] |=> !rise_o[l]); // R3
  end
endmodule

// File: rtl/dcc_mode.sv
`timescale 1ns/1ps
module dcc_mode
  import dcc_pkg::*;
(
  input  logic      clk_i,
  input  logic      clr_i,
  input  logic      load_n_i,
  input  logic      rise_up_i,
  input  logic      rise_dn_i,
  output dcc_mode_e mode_o
);
  // Priority: clear, load, then a lone edge; two edges cancel out
  always_comb begin
    if (clr_i)                       mode_o = MODE_CLEAR;
    else if (!load_n_i)              mode_o = MODE_LOAD;
    else if (rise_up_i && !rise_dn_i) mode_o = MODE_UP;
    else if (rise_dn_i && !rise_up_i) mode_o = MODE_DOWN;
    else                             mode_o = MODE_HOLD;
  end

  AST_DUAL_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
    (load_n_i && rise_up_i && rise_dn_i) |-> (mode_o == MODE_HOLD)); // R7
endmodule

// File: rtl/dcc_core.sv
`timescale 1ns/1ps
module dcc_core
  import dcc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  dcc_mode_e        mode_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return CNT_W'(v + 1'b1);
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] v);
    return CNT_W'(v - 1'b1);
  endfunction

  always_ff @(posedge clk_i) begin
    case (mode_i)
      MODE_CLEAR: count_q <= '0;
      MODE_LOAD:  count_q <= data_i;
      MODE_UP:    count_q <= step_up(count_q);
      MODE_DOWN:  count_q <= step_dn(count_q);
      default:    count_q <= count_q;
    endcase
  end

  assign count_o = count_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    clr_i |=> (count_q == '0)); // R1
  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (clr_i)
    (mode_i == MODE_LOAD) |=> (count_q == $past(data_i))); // R2
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (clr_i)
    (mode_i == MODE_UP) |=> (count_q == CNT_W'($past(count_q) + 1'b1))); // R3
  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (clr_i)
    (mode_i == MODE_DOWN) |=> (count_q == CNT_W'($past(count_q) - 1'b1))); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (clr_i)
    (mode_i == MODE_HOLD) |=> $stable(count_q)); // R6
endmodule

// File: rtl/dcc_term.sv
`timescale 1ns/1ps
module dcc_term #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  function automatic logic at_max(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  function automatic logic at_zero(input logic [CNT_W-1:0] v);
    return ~|v;
  endfunction

  // Gated by the line level itself so the output repeats its low pulse
  assign carry_n_o  = ~(at_max(count_i)  & ~up_lvl_i);
  assign borrow_n_o = ~(at_zero(count_i) & ~dn_lvl_i);

  AST_CARRY_IDLE: assert property (@(posedge clk_i) disable iff (clr_i)
    up_lvl_i |-> carry_n_o); // R8
  AST_BORROW_IDLE: assert property (@(posedge clk_i) disable iff (clr_i)
    dn_lvl_i |-> borrow_n_o); // R9
  AST_TC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (clr_i)
    carry_n_o || borrow_n_o); // R8
endmodule

// File: rtl/dcc_counter.sv
`timescale 1ns/1ps
module dcc_counter
  import dcc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_lvl;
  logic [N_LINES-1:0] line_rise;
  dcc_mode_e          mode;
  logic [CNT_W-1:0]   count;

  assign line_raw[LINE_UP] = up_i;
  assign line_raw[LINE_DN] = dn_i;

  dcc_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .clr_i  (clr_i),
    .raw_i  (line_raw),
    .lvl_o  (line_lvl),
    .rise_o (line_rise)
  );

  dcc_mode i_mode (
    .clk_i     (clk_i),
    .clr_i     (clr_i),
    .load_n_i  (load_n_i),
    .rise_up_i (line_rise[LINE_UP]),
    .rise_dn_i (line_rise[LINE_DN]),
    .mode_o    (mode)
  );

  dcc_core #(.CNT_W(CNT_W)) i_core (
    .clk_i   (clk_i),
    .clr_i   (clr_i),
    .mode_i  (mode),
    .data_i  (data_i),
    .count_o (count)
  );

  dcc_term #(.CNT_W(CNT_W)) i_term (
    .clk_i      (clk_i),
    .clr_i      (clr_i),
    .count_i    (count),
    .up_lvl_i   (line_lvl[LINE_UP]),
    .dn_lvl_i   (line_lvl[LINE_DN]),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  assign count_o = count;
endmodule

// File: tb/test_dcc_counter.sv
`timescale 1ns/1ps
module test_dcc_counter;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] data = 4'd0;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic [3:0] count;
  logic       carry_n;
  logic       borrow_n;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  dcc_counter i_dcc_counter (
    .clk_i(clk), .clr_i(clr), .load_n_i(load_n), .data_i(data),
    .up_i(up), .dn_i(dn), .count_o(count), .carry_n_o(carry_n), .borrow_n_o(borrow_n)
  );

  // Vector: {op[1:0], data[3:0], expected[3:0]}; op 0 clear, 1 load, 2 up, 3 down
  localparam int NV = 16;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 4'd0,  4'd0},  {2'd2, 4'd0, 4'd1},  {2'd2, 4'd0, 4'd2},  {2'd3, 4'd0, 4'd1},
    {2'd3, 4'd0,  4'd0},  {2'd3, 4'd0, 4'd15}, {2'd2, 4'd0, 4'd0},  {2'd1, 4'd9, 4'd9},
    {2'd2, 4'd0,  4'd10}, {2'd1, 4'd14, 4'd14},{2'd2, 4'd0, 4'd15}, {2'd2, 4'd0, 4'd0},
    {2'd1, 4'd3,  4'd3},  {2'd3, 4'd0, 4'd2},  {2'd0, 4'd0, 4'd0},  {2'd1, 4'd15, 4'd15}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear;
    clr = 1'b1; cyc(2); clr = 1'b0; cyc(4);
  endtask

  task automatic do_load(input logic [3:0] v);
    data = v; load_n = 1'b0; cyc(2); load_n = 1'b1; cyc(1);
  endtask

  task automatic pulse_up;
    up = 1'b0; cyc(4); up = 1'b1; cyc(4);
  endtask

  task automatic pulse_dn;
    dn = 1'b0; cyc(4); dn = 1'b1; cyc(4);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(5);
    // R1 reset state
    chk("R1 count after clear", int'(count), 0);
    chk("R8 carry idle after clear", int'(carry_n), 1);
    chk("R9 borrow idle after clear", int'(borrow_n), 1);
    clr = 1'b0; cyc(4);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] dv, ev;
      string tag;
      op = VEC[i][9:8]; dv = VEC[i][7:4]; ev = VEC[i][3:0];
      case (op)
        2'd0: begin do_clear(); tag = "R1"; end
        2'd1: begin do_load(dv); tag = "R2"; end
        2'd2: begin pulse_up(); tag = (ev == 4'd0) ? "R5 up wrap" : "R3"; end
        default: begin pulse_dn(); tag = (ev == 4'd15) ? "R5 down wrap" : "R4"; end
      endcase
      chk(tag, int'(count), int'(ev));
    end

    // R1 clear overrides load and count activity
    data = 4'd5; load_n = 1'b0; clr = 1'b1; up = 1'b0; cyc(2); up = 1'b1; cyc(3);
    chk("R1 clear beats load and up", int'(count), 0);
    load_n = 1'b1; clr = 1'b0; cyc(4);

    // R2 load overrides an up edge arriving during load; the edge is dropped
    data = 4'd7; load_n = 1'b0; up = 1'b0; cyc(3); up = 1'b1; cyc(4);
    load_n = 1'b1; cyc(4);
    chk("R2 load beats up edge", int'(count), 7);

    // R6 both lines high hold the count
    cyc(10);
    chk("R6 hold with lines high", int'(count), 7);

    // R8 carry timing at the maximum count
    do_load(4'd15);
    up = 1'b0; cyc(4);
    chk("R8 carry low at 15 with up low", int'(carry_n), 0);
    chk("R9 borrow high at 15", int'(borrow_n), 1);
    up = 1'b1; cyc(1);
    chk("R8 carry still low one edge after up rises", int'(carry_n), 0);
    cyc(1);
    chk("R8 carry released two edges after up rises", int'(carry_n), 1);
    chk("R3 count not yet stepped", int'(count), 15);
    cyc(1);
    chk("R3 count stepped at third edge", int'(count), 0);
    do_load(4'd14); up = 1'b0; cyc(4);
    chk("R8 carry high at 14 with up low", int'(carry_n), 1);
    up = 1'b1; cyc(4);

    // R9 borrow at zero
    do_load(4'd0); dn = 1'b0; cyc(4);
    chk("R9 borrow low at 0 with down low", int'(borrow_n), 0);
    chk("R8 carry high at 0", int'(carry_n), 1);
    dn = 1'b1; cyc(4);
    chk("R9 borrow released after down rises", int'(borrow_n), 1);
    chk("R5 down wrap via borrow pulse", int'(count), 15);

    // R10 pending low line across load
    up = 1'b0; cyc(2); data = 4'd4; load_n = 1'b0; cyc(3); load_n = 1'b1; cyc(4);
    up = 1'b1; cyc(4);
    chk("R10 edge counted after load release", int'(count), 5);

    // R10 pending low line across clear
    dn = 1'b0; cyc(2); clr = 1'b1; cyc(3); clr = 1'b0; cyc(4);
    dn = 1'b1; cyc(4);
    chk("R10 edge counted after clear release", int'(count), 15);

    // R7 simultaneous rising edges hold
    do_load(4'd6); up = 1'b0; dn = 1'b0; cyc(4);
    up = 1'b1; dn = 1'b1; cyc(5);
    chk("R7 dual edge holds", int'(count), 6);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule